// File: doc/BRIEF.md
# Three-Operand Address Generator with Run-Time Address Width

This block forms a virtual address from three parts: a base register value, an index register value and a short unsigned offset. It adds them and wraps the sum into one of three address spaces, selected on each request. In the narrowest space only the low 24 bits survive. The middle space keeps 31 bits. The widest space keeps the full 64 bits, and any carry beyond the top bit is lost. An operand whose present flag is low counts as zero. Instructions that omit a base or an index register can therefore use the same path.

Requests arrive with a valid strobe. The address appears one clock later, registered, with its own valid flag. A new request can be issued on every cycle. Inside, the three operands are first reduced to two vectors by a carry-save row. A single carry-propagate adder then produces the sum, and a mode-selected mask clears the unused high bits before the output register.

Top module: `vaddr_agen`

## Requirements
- R1: With `amode` = 2'b10, `ea_out` equals (base + index + offset) modulo 2^64. A carry out of bit 63 is discarded.
- R2: With `amode` = 2'b00, `ea_out[23:0]` equals the low 24 bits of the sum, and bits 63:24 are zero.
- R3: With `amode` = 2'b01, `ea_out[30:0]` equals the low 31 bits of the sum, and bits 63:31 are zero.
- R4: The encoding `amode` = 2'b11 behaves exactly as 2'b10, keeping the full 64-bit sum.
- R5: When `base_use` is low, `base_val` has no effect and the base operand counts as zero.
- R6: When `index_use` is low, `index_val` has no effect and the index operand counts as zero.
- R7: `disp` is a 12-bit unsigned value, zero-extended before the add. For example, 12'hFFF adds 4095.
- R8: `ea_valid` in a cycle equals `req_valid` of the cycle before. Requests issued on back-to-back cycles each give their own result one clock later.
- R9: In a cycle after `req_valid` was low, `ea_out` keeps its previous value.
- R10: While `rst` is high, the next clock edge drives `ea_valid` low and `ea_out` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| base_val | input | 64 | Base register value |
| index_val | input | 64 | Index register value |
| base_use | input | 1 | Base operand present; when low, the base counts as zero |
| index_use | input | 1 | Index operand present; when low, the index counts as zero |
| disp | input | 12 | Unsigned offset |
| amode | input | 2 | Address width: 00 = 24-bit, 01 = 31-bit, 10 or 11 = 64-bit |
| ea_out | output | 64 | Registered effective address |
| ea_valid | output | 1 | `ea_out` carries a new result this cycle |

## Verification
On every cycle, the bound checker compares the registered address against a plain sum of the gated ports in each mode. It also checks that the high bits are cleared in the two narrow modes, that the valid flag follows the strobe by one cycle, that the address holds on idle cycles, and what reset leaves behind. The bench's sweep is what shows the edge cases that random traffic would rarely reach. These are carries that cross bit 24, bit 31 and bit 63, the all-ones offset, and a large base or index value that its cleared present flag must suppress. The sweep also shows that the reserved mode code is handled correctly.

// File: rtl/agen_pkg.sv
package agen_pkg;

    typedef enum logic [1:0] {
        AM_NARROW = 2'b00,
        AM_MID    = 2'b01,
        AM_WIDE   = 2'b10,
        AM_WIDE_R = 2'b11
    } amode_e;

    // True when the mode keeps every bit of the sum.
    function automatic logic is_wide(amode_e m);
        return (m == AM_WIDE) || (m == AM_WIDE_R);
    endfunction

endpackage

// File: rtl/agen_operand_gate.sv
module agen_operand_gate #(
    parameter int ADDR_W = 64,
    parameter int DISP_W = 12
) (
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] index_val,
    input  logic              base_use,
    input  logic              index_use,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] op_base,
    output logic [ADDR_W-1:0] op_index,
    output logic [ADDR_W-1:0] op_disp
);
    localparam int PAD_W = ADDR_W - DISP_W;

    always_comb begin
        op_base  = base_use  ? base_val  : '0;
        op_index = index_use ? index_val : '0;
        op_disp  = {{PAD_W{1'b0}}, disp};
    end
endmodule

// File: rtl/agen_csa.sv
module agen_csa #(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] in_a,
    input  logic [ADDR_W-1:0] in_b,
    input  logic [ADDR_W-1:0] in_c,
    output logic [ADDR_W-1:0] psum,
    output logic [ADDR_W-1:0] pcarry
);
    logic [ADDR_W-1:0] maj;

    // One full adder per bit position; the carry vector is shifted left by one.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_fa
        assign psum[i] = in_a[i] ^ in_b[i] ^ in_c[i];
        assign maj[i]  = (in_a[i] & in_b[i]) | (in_a[i] & in_c[i]) | (in_b[i] & in_c[i]);
    end

    // The majority bit from the top position leaves the word: this is the wrap modulo 2^ADDR_W.
    assign pcarry = {maj[ADDR_W-2:0], 1'b0};

    logic unused_top;
    assign unused_top = maj[ADDR_W-1];
endmodule

// File: rtl/agen_mode_mask.sv
module agen_mode_mask
    import agen_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int NARROW_W = 24,
    parameter int MID_W    = 31
) (
    input  amode_e            mode,
    input  logic [ADDR_W-1:0] raw,
    output logic [ADDR_W-1:0] masked
);
    localparam logic [ADDR_W-1:0] KEEP_NARROW = {{(ADDR_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    localparam logic [ADDR_W-1:0] KEEP_MID    = {{(ADDR_W-MID_W){1'b0}}, {MID_W{1'b1}}};

    logic [ADDR_W-1:0] keep;

    always_comb begin
        unique case (mode)
            AM_NARROW: keep = KEEP_NARROW;
            AM_MID:    keep = KEEP_MID;
            default:   keep = '1;
        endcase
        masked = raw & keep;
    end
endmodule

// File: rtl/vaddr_agen.sv
module vaddr_agen
    import agen_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int DISP_W   = 12,
    parameter int NARROW_W = 24,
    parameter int MID_W    = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] index_val,
    input  logic              base_use,
    input  logic              index_use,
    input  logic [DISP_W-1:0] disp,
    input  logic [1:0]        amode,
    output logic [ADDR_W-1:0] ea_out,
    output logic              ea_valid
);
    logic [ADDR_W-1:0] op_base, op_index, op_disp;
    logic [ADDR_W-1:0] psum, pcarry;
    logic [ADDR_W-1:0] raw_sum, next_ea;
    amode_e            mode;

    assign mode = amode_e'(amode);

    agen_operand_gate #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_gate (
        .base_val (base_val),
        .index_val(index_val),
        .base_use (base_use),
        .index_use(index_use),
        .disp     (disp),
        .op_base  (op_base),
        .op_index (op_index),
        .op_disp  (op_disp)
    );

    agen_csa #(.ADDR_W(ADDR_W)) u_csa (
        .in_a  (op_base),
        .in_b  (op_index),
        .in_c  (op_disp),
        .psum  (psum),
        .pcarry(pcarry)
    );

    // Single carry-propagate add; the carry out of the top bit is dropped.
    assign raw_sum = psum + pcarry;

    agen_mode_mask #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W), .MID_W(MID_W)) u_mask (
        .mode  (mode),
        .raw   (raw_sum),
        .masked(next_ea)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ea_valid <= 1'b0;
            ea_out   <= '0;
        end else begin
            ea_valid <= req_valid;
            if (req_valid) ea_out <= next_ea;
        end
    end
endmodule

// File: rtl/vaddr_agen_chk.sv
module vaddr_agen_chk #(
    parameter int ADDR_W   = 64,
    parameter int DISP_W   = 12,
    parameter int NARROW_W = 24,
    parameter int MID_W    = 31
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [ADDR_W-1:0] base_val,
    input logic [ADDR_W-1:0] index_val,
    input logic              base_use,
    input logic              index_use,
    input logic [DISP_W-1:0] disp,
    input logic [1:0]        amode,
    input logic [ADDR_W-1:0] ea_out,
    input logic              ea_valid
);
    logic [ADDR_W-1:0] ref_sum;

    always_comb begin
        ref_sum = (base_use ? base_val : '0) + (index_use ? index_val : '0)
                + {{(ADDR_W-DISP_W){1'b0}}, disp};
    end

    AST_WIDE_SUM: assert property (@(posedge clk) disable iff (rst)
        (req_valid && amode[1]) |=> (ea_out == $past(ref_sum)));   // R1
    AST_NARROW_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (req_valid && amode == 2'b00) |=> (ea_out >> NARROW_W) == '0);   // R2
    AST_NARROW_LOW: assert property (@(posedge clk) disable iff (rst)
        (req_valid && amode == 2'b00) |=> ea_out[NARROW_W-1:0] == $past(ref_sum[NARROW_W-1:0]));   // R2
    AST_MID_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (req_valid && amode == 2'b01) |=> (ea_out >> MID_W) == '0);   // R3
    AST_MID_LOW: assert property (@(posedge clk) disable iff (rst)
        (req_valid && amode == 2'b01) |=> ea_out[MID_W-1:0] == $past(ref_sum[MID_W-1:0]));   // R3
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> ea_valid);   // R8
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !ea_valid);   // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(ea_out));   // R9
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (!ea_valid && ea_out == '0));   // R10
endmodule

bind vaddr_agen vaddr_agen_chk #(
    .ADDR_W(ADDR_W), .DISP_W(DISP_W), .NARROW_W(NARROW_W), .MID_W(MID_W)
) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .base_val(base_val),
    .index_val(index_val), .base_use(base_use), .index_use(index_use),
    .disp(disp), .amode(amode), .ea_out(ea_out), .ea_valid(ea_valid)
);

// File: tb/sim_vaddr_agen.sv
module sim_vaddr_agen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [63:0] base_val = '0, index_val = '0;
    logic        base_use = 1'b0, index_use = 1'b0;
    logic [11:0] disp = '0;
    logic [1:0]  amode = 2'b00;
    logic [63:0] ea_out;
    logic        ea_valid;

    int n_cmp = 0;
    int n_bad = 0;

    always #10ns clk = ~clk;

    vaddr_agen u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .base_val(base_val),
        .index_val(index_val), .base_use(base_use), .index_use(index_use),
        .disp(disp), .amode(amode), .ea_out(ea_out), .ea_valid(ea_valid)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input logic [63:0] b, input logic [63:0] x,
                                          input logic bu, input logic xu,
                                          input logic [11:0] d, input logic [1:0] m);
        logic [64:0] full;
        full = {1'b0, (bu ? b : 64'd0)} + {1'b0, (xu ? x : 64'd0)} + {53'd0, d};
        case (m)
            2'b00:   return full[63:0] & 64'h0000_0000_00FF_FFFF;
            2'b01:   return full[63:0] & 64'h0000_0000_7FFF_FFFF;
            default: return full[63:0];
        endcase
    endfunction

    function automatic string req_of(input logic [1:0] m, input logic bu, input logic xu);
        if (!bu)        return "R5";
        if (!xu)        return "R6";
        if (m == 2'b00) return "R2";
        if (m == 2'b01) return "R3";
        if (m == 2'b11) return "R4";
        return "R1";
    endfunction

    logic [63:0] pats [6];
    logic [11:0] disps [4];

    initial begin
        pats[0] = 64'h0000_0000_0000_0000;
        pats[1] = 64'h0000_0000_00FF_F800;
        pats[2] = 64'h0000_0000_7FFF_F000;
        pats[3] = 64'hFFFF_FFFF_FFFF_FFFF;
        pats[4] = 64'h8000_0000_0000_0801;
        pats[5] = 64'h1234_5678_9ABC_DEF0;
        disps[0] = 12'h000; disps[1] = 12'h001; disps[2] = 12'hFFF; disps[3] = 12'h800;
    end

    initial begin
        logic [63:0] exp_ea;
        string       exp_req;
        logic        pending;

        // R10: reset state
        repeat (3) @(negedge clk);
        check("R10 valid", {63'd0, ea_valid}, 64'd0);
        check("R10 addr", ea_out, 64'd0);

        // R7: offset alone is zero-extended in the widest mode
        rst = 1'b0;
        req_valid = 1'b1; base_use = 1'b0; index_use = 1'b0;
        base_val = '1; index_val = '1; disp = 12'hFFF; amode = 2'b10;
        @(negedge clk);
        check("R7 offset", ea_out, 64'd4095);
        check("R8 valid", {63'd0, ea_valid}, 64'd1);

        // Back-to-back sweep: each cycle checks the previous request (R8)
        pending = 1'b0;
        exp_ea = '0;
        exp_req = "";
        for (int m = 0; m < 4; m++)
            for (int f = 0; f < 4; f++)
                for (int bi = 0; bi < 6; bi++)
                    for (int xi = 0; xi < 6; xi++)
                        for (int di = 0; di < 4; di++) begin
                            req_valid = 1'b1;
                            amode     = 2'(m);
                            base_use  = f[0];
                            index_use = f[1];
                            base_val  = pats[bi];
                            index_val = pats[5 - xi];
                            disp      = disps[di];
                            @(negedge clk);
                            if (pending) begin end
                            check(exp_req.len() == 0 ? "R8" : {exp_req, " addr"},
                                  ea_out, model(pats[bi], pats[5 - xi], f[0], f[1], disps[di], 2'(m)));
                            check("R8 valid", {63'd0, ea_valid}, 64'd1);
                            exp_req = req_of(2'(m), f[0], f[1]);
                            pending = 1'b1;
                        end

        // R9: idle cycles hold the address and drop valid
        exp_ea = ea_out;
        req_valid = 1'b0;
        base_use = 1'b1; index_use = 1'b1;
        base_val = 64'hDEAD_BEEF_0000_0001; index_val = 64'h5; disp = 12'h3; amode = 2'b10;
        @(negedge clk);
        check("R9 hold", ea_out, exp_ea);
        check("R8 idle valid", {63'd0, ea_valid}, 64'd0);
        @(negedge clk);
        check("R9 hold2", ea_out, exp_ea);

        // R2 carry across bit 24 is dropped
        req_valid = 1'b1; amode = 2'b00;
        base_val = 64'h0000_0000_00FF_FFFF; index_val = 64'h0; disp = 12'h001;
        @(negedge clk);
        check("R2 wrap", ea_out, 64'd0);

        // R3 carry across bit 31 is dropped
        amode = 2'b01;
        base_val = 64'h0000_0000_7FFF_FFFF; index_val = 64'h1; disp = 12'h000;
        @(negedge clk);
        check("R3 wrap", ea_out, 64'd0);

        // R1 carry out of bit 63 is dropped
        amode = 2'b10;
        base_val = 64'hFFFF_FFFF_FFFF_FFFF; index_val = 64'h1; disp = 12'h002;
        @(negedge clk);
        check("R1 wrap", ea_out, 64'd2);

        // R10: reset mid-run clears output
        rst = 1'b1;
        @(negedge clk);
        check("R10 clear valid", {63'd0, ea_valid}, 64'd0);
        check("R10 clear addr", ea_out, 64'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20ns * 100000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule